// File: doc/BRIEF.md
# Firmware Download Mailbox Pair

This block sits between a byte-wide host register port and an embedded processor. It holds two 32-byte first-in-first-out mailboxes. The inbound mailbox carries a firmware image from the host to the processor. The outbound mailbox carries replies from the processor back to the host. The host reaches both mailboxes, their status and a control/flag register through a 6-bit address space. A fixed register reports whether the processor is ready to take a download.

Download data travels as 16-bit words in little-endian order, written as two bytes. If the image on the host side is big-endian, the host sets the swap option. The block then holds the first byte of each pair and enters the two bytes into the inbound mailbox in exchanged order.

On the processor side both mailboxes are valid/ready streams. For the inbound stream, `proc_in_valid` is high whenever the mailbox holds data, and a byte leaves the mailbox on any clock edge where valid and ready are both high. For the outbound stream, `proc_out_ready` is low while that mailbox is full. The processor must then hold `proc_out_valid` and its data until ready returns; a byte is taken only on an edge where both are high. The host side has no back-pressure. The host uses status reads to pace itself, and the sticky flags record any write or read that was lost.

Top module: `fw_mailbox`

## Requirements
- R1: After reset both mailboxes are empty, the flag register (0x04) reads 0x00, `irq` and `proc_in_valid` are low, and `host_rdata` is 0x00.
- R2: A read of address 0x16 returns 0x01 while `proc_dl_ready` is high and 0x00 while it is low.
- R3: Bytes written to address 0x00 leave on `proc_in_data` in the order they were written. `proc_in_valid` is high exactly while the inbound mailbox holds at least one byte.
- R4: Reads of addresses 0x02 (inbound) and 0x03 (outbound) return a status byte. Bit 7 is full, bit 6 is empty, and bits 5:0 are the number of bytes held.
- R5: Each mailbox holds at most 32 bytes. A write to a full inbound mailbox is discarded and sets the sticky overflow flag, bit 0 of 0x04. This holds even if the processor pops in the same cycle.
- R6: The outbound mailbox accepts a processor byte when valid and ready are both high. Reads of 0x01 return the held bytes in order. Read data appears on `host_rdata` one clock after the read strobe.
- R7: A read of 0x01 while the outbound mailbox is empty returns 0x00 and sets the sticky underflow flag, bit 1 of 0x04.
- R8: `irq` is high exactly while the outbound mailbox is not empty.
- R9: With the swap bit (bit 2 of 0x04) set, writes to 0x00 are taken in pairs, and the second byte of each pair enters the mailbox before the first. A held first byte does not count in the status.
- R10: Writing 0x04 clears each flag whose bit is written 1 and loads the swap bit from bit 2. Changing the swap bit discards any held first byte.
- R11: A host push and a processor pop of the inbound mailbox in the same cycle leave its count unchanged. The same holds for a processor push and a host pop of the outbound mailbox.
- R12: A read of an unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 6 | Host register address |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid one clock after the read strobe |
| proc_dl_ready | input | 1 | Processor can accept a download |
| proc_in_valid | output | 1 | Inbound mailbox has a byte for the processor |
| proc_in_ready | input | 1 | Processor takes the inbound byte |
| proc_in_data | output | 8 | Inbound head byte |
| proc_out_valid | input | 1 | Processor offers an outbound byte |
| proc_out_ready | output | 1 | Outbound mailbox has room |
| proc_out_data | input | 8 | Outbound byte from the processor |
| irq | output | 1 | Outbound mailbox not empty |

## Verification
Each mailbox has one writer and one reader on opposite sides, so a push and a pop can land on the same edge. The bench provokes this for the inbound mailbox by putting a host write to 0x00 and `proc_in_ready` into one cycle while a byte is held. It then checks that the popped byte is the old head and that the status count is unchanged. For the outbound mailbox it pairs a host read of 0x01 with a processor push. It judges the result by the returned byte, the unchanged count and the order of the remaining data. The bench also fills the inbound mailbox to 32 bytes and checks that the write arriving on a full mailbox is lost while the earlier bytes drain intact.

// File: rtl/fwmb_pkg.sv
package fwmb_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] REG_IN_DATA  = 6'h00;
  localparam logic [ADDR_W-1:0] REG_OUT_DATA = 6'h01;
  localparam logic [ADDR_W-1:0] REG_IN_STAT  = 6'h02;
  localparam logic [ADDR_W-1:0] REG_OUT_STAT = 6'h03;
  localparam logic [ADDR_W-1:0] REG_CTRL     = 6'h04;
  localparam logic [ADDR_W-1:0] REG_READY    = 6'h16;

  localparam int BIT_OVF  = 0;
  localparam int BIT_UNF  = 1;
  localparam int BIT_SWAP = 2;

  typedef struct packed {
    logic       full;
    logic       empty;
    logic [5:0] count;
  } fifo_stat_t;
endpackage

// File: rtl/fwmb_fifo.sv
module fwmb_fifo #(
  parameter int DEPTH = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push1,
  input  logic          push2,
  input  logic [7:0]    d0,
  input  logic [7:0]    d1,
  input  logic          pop,
  output logic          accepted,
  output logic          dropped,
  output logic [7:0]    head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [1:0]    need;
  logic          pop_ok;

  assign need     = push2 ? 2'd2 : (push1 ? 2'd1 : 2'd0);
  assign accepted = (need != 2'd0) && (CW'(DEPTH) - count >= CW'(need));
  assign dropped  = (need != 2'd0) && !accepted;
  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign pop_ok   = pop && !empty;
  assign head     = mem[rptr];

  always_ff @(posedge clk) begin
    if (accepted) begin
      mem[wptr] <= d0;
      if (push2) mem[wptr + PW'(1)] <= d1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (accepted) wptr <= wptr + PW'(need);
      if (pop_ok)   rptr <= rptr + PW'(1);
      count <= count + (accepted ? CW'(need) : CW'(0)) - (pop_ok ? CW'(1) : CW'(0));
    end
  end
endmodule

// File: rtl/fwmb_swap.sv
module fwmb_swap (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       swap_en,
  input  logic       discard,
  output logic       push1,
  output logic       push2,
  output logic [7:0] d0,
  output logic [7:0] d1
);
  logic       half;
  logic [7:0] hold;

  always_comb begin
    push1 = 1'b0;
    push2 = 1'b0;
    d0    = wdata;
    d1    = hold;
    if (wr && !swap_en)         push1 = 1'b1;
    else if (wr && swap_en && half) push2 = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half <= 1'b0;
      hold <= '0;
    end else if (discard) begin
      half <= 1'b0;
    end else if (wr && swap_en) begin
      if (!half) hold <= wdata;
      half <= !half;
    end
  end
endmodule

// File: rtl/fw_mailbox.sv
module fw_mailbox
  import fwmb_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              proc_dl_ready,
  output logic              proc_in_valid,
  input  logic              proc_in_ready,
  output logic [BYTE_W-1:0] proc_in_data,
  input  logic              proc_out_valid,
  output logic              proc_out_ready,
  input  logic [BYTE_W-1:0] proc_out_data,
  output logic              irq
);
  logic          wr_in, wr_ctrl, rd_out;
  logic          sw_push1, sw_push2, sw_discard;
  logic [7:0]    sw_d0, sw_d1;
  logic          in_acc, in_drop, in_full, in_empty;
  logic [CW-1:0] in_cnt;
  logic          out_acc, out_drop, out_full, out_empty;
  logic [CW-1:0] out_cnt;
  logic [7:0]    out_head;
  logic          ovf, unf, swap_en;
  fifo_stat_t    in_stat, out_stat;
  logic [7:0]    rd_mux;

  assign wr_in      = host_wr && (host_addr == REG_IN_DATA);
  assign wr_ctrl    = host_wr && (host_addr == REG_CTRL);
  assign rd_out     = host_rd && (host_addr == REG_OUT_DATA);
  assign sw_discard = wr_ctrl && (host_wdata[BIT_SWAP] != swap_en);

  fwmb_swap u_swap (
    .clk(clk), .rst_n(rst_n), .wr(wr_in), .wdata(host_wdata),
    .swap_en(swap_en), .discard(sw_discard),
    .push1(sw_push1), .push2(sw_push2), .d0(sw_d0), .d1(sw_d1)
  );

  fwmb_fifo #(.DEPTH(DEPTH)) u_in (
    .clk(clk), .rst_n(rst_n), .push1(sw_push1), .push2(sw_push2),
    .d0(sw_d0), .d1(sw_d1), .pop(proc_in_ready),
    .accepted(in_acc), .dropped(in_drop), .head(proc_in_data),
    .count(in_cnt), .full(in_full), .empty(in_empty)
  );

  fwmb_fifo #(.DEPTH(DEPTH)) u_out (
    .clk(clk), .rst_n(rst_n), .push1(proc_out_valid), .push2(1'b0),
    .d0(proc_out_data), .d1(8'h00), .pop(rd_out),
    .accepted(out_acc), .dropped(out_drop), .head(out_head),
    .count(out_cnt), .full(out_full), .empty(out_empty)
  );

  assign proc_in_valid  = !in_empty;
  assign proc_out_ready = !out_full;
  assign irq            = !out_empty;

  assign in_stat  = '{full: in_full,  empty: in_empty,  count: 6'(in_cnt)};
  assign out_stat = '{full: out_full, empty: out_empty, count: 6'(out_cnt)};

  always_comb begin
    unique case (host_addr)
      REG_OUT_DATA: rd_mux = out_empty ? 8'h00 : out_head;
      REG_IN_STAT:  rd_mux = in_stat;
      REG_OUT_STAT: rd_mux = out_stat;
      REG_CTRL:     rd_mux = {5'b0, swap_en, unf, ovf};
      REG_READY:    rd_mux = {7'b0, proc_dl_ready};
      default:      rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
      ovf        <= 1'b0;
      unf        <= 1'b0;
      swap_en    <= 1'b0;
    end else begin
      if (host_rd) host_rdata <= rd_mux;
      if (wr_ctrl) begin
        swap_en <= host_wdata[BIT_SWAP];
        if (host_wdata[BIT_OVF]) ovf <= 1'b0;
        if (host_wdata[BIT_UNF]) unf <= 1'b0;
      end
      if (in_drop)             ovf <= 1'b1;
      if (rd_out && out_empty) unf <= 1'b1;
    end
  end
endmodule

// File: rtl/fw_mailbox_chk.sv
module fw_mailbox_chk #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [5:0]    host_addr,
  input logic          host_wr,
  input logic          host_rd,
  input logic [7:0]    host_rdata,
  input logic          proc_in_valid,
  input logic          proc_in_ready,
  input logic          proc_out_valid,
  input logic          proc_out_ready,
  input logic          irq,
  input logic [CW-1:0] in_cnt,
  input logic [CW-1:0] out_cnt,
  input logic          ovf,
  input logic          unf,
  input logic          swap_en
);
  // R5
  in_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_cnt <= CW'(DEPTH));
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 6'h00 && !swap_en && in_cnt == CW'(DEPTH)) |=> (ovf && in_cnt <= CW'(DEPTH)));
  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 6'h01 && out_cnt == '0) |=> (host_rdata == 8'h00 && unf));
  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(proc_out_valid && proc_out_ready));
  // R3
  in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proc_in_valid |-> (in_cnt != '0));
  // R11
  in_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_in_valid && proc_in_ready && host_wr && host_addr == 6'h00 && !swap_en && in_cnt < CW'(DEPTH))
    |=> $stable(in_cnt));
endmodule

bind fw_mailbox fw_mailbox_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_rd(host_rd), .host_rdata(host_rdata), .proc_in_valid(proc_in_valid),
  .proc_in_ready(proc_in_ready), .proc_out_valid(proc_out_valid),
  .proc_out_ready(proc_out_ready), .irq(irq), .in_cnt(in_cnt),
  .out_cnt(out_cnt), .ovf(ovf), .unf(unf), .swap_en(swap_en)
);

// File: tb/fw_mailbox_test.sv
module fw_mailbox_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 28;
  // kind: 0 host write, 1 host read and compare, 2 processor pop and compare, 3 processor push
  localparam logic [31:0] VEC [NV] = '{
    {2'd1, 6'h16, 8'h00, 8'h01, 8'd2},   // R2 ready
    {2'd1, 6'h02, 8'h00, 8'h40, 8'd1},   // R1 empty inbound
    {2'd0, 6'h00, 8'hA1, 8'h00, 8'd3},
    {2'd0, 6'h00, 8'hB2, 8'h00, 8'd3},
    {2'd0, 6'h00, 8'hC3, 8'h00, 8'd3},
    {2'd1, 6'h02, 8'h00, 8'h03, 8'd4},   // R4 count 3
    {2'd2, 6'h00, 8'h00, 8'hA1, 8'd3},   // R3 order
    {2'd2, 6'h00, 8'h00, 8'hB2, 8'd3},
    {2'd1, 6'h02, 8'h00, 8'h01, 8'd4},
    {2'd2, 6'h00, 8'h00, 8'hC3, 8'd3},
    {2'd1, 6'h02, 8'h00, 8'h40, 8'd4},
    {2'd3, 6'h00, 8'h5A, 8'h00, 8'd6},
    {2'd3, 6'h00, 8'h6B, 8'h00, 8'd6},
    {2'd1, 6'h03, 8'h00, 8'h02, 8'd4},   // R4 outbound count
    {2'd1, 6'h01, 8'h00, 8'h5A, 8'd6},   // R6 order
    {2'd1, 6'h01, 8'h00, 8'h6B, 8'd6},
    {2'd1, 6'h03, 8'h00, 8'h40, 8'd4},
    {2'd1, 6'h01, 8'h00, 8'h00, 8'd7},   // R7 empty read
    {2'd1, 6'h04, 8'h00, 8'h02, 8'd7},   // R7 underflow flag
    {2'd0, 6'h04, 8'h02, 8'h00, 8'd10},
    {2'd1, 6'h04, 8'h00, 8'h00, 8'd10},  // R10 cleared
    {2'd0, 6'h04, 8'h04, 8'h00, 8'd9},   // R9 swap on
    {2'd0, 6'h00, 8'h11, 8'h00, 8'd9},
    {2'd0, 6'h00, 8'h22, 8'h00, 8'd9},
    {2'd1, 6'h02, 8'h00, 8'h02, 8'd9},
    {2'd2, 6'h00, 8'h00, 8'h22, 8'd9},   // R9 second byte first
    {2'd2, 6'h00, 8'h00, 8'h11, 8'd9},
    {2'd1, 6'h3F, 8'h00, 8'h00, 8'd12}   // R12 unmapped
  };

  logic clk = 0, rst_n = 0;
  logic [5:0] host_addr = 0;
  logic host_wr = 0, host_rd = 0, proc_dl_ready = 0;
  logic [7:0] host_wdata = 0, host_rdata, proc_in_data, proc_out_data = 0;
  logic proc_in_valid, proc_in_ready = 0, proc_out_valid = 0, proc_out_ready, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fw_mailbox uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .proc_dl_ready(proc_dl_ready), .proc_in_valid(proc_in_valid),
    .proc_in_ready(proc_in_ready), .proc_in_data(proc_in_data),
    .proc_out_valid(proc_out_valid), .proc_out_ready(proc_out_ready),
    .proc_out_data(proc_out_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [5:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic hread(input logic [5:0] a, input logic [7:0] exp, input string tag);
    host_addr = a; host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    chk(tag, host_rdata, exp);
  endtask

  task automatic ppop(input logic [7:0] exp, input string tag);
    chk({tag, " valid"}, {7'b0, proc_in_valid}, 8'h01);
    chk(tag, proc_in_data, exp);
    proc_in_ready = 1;
    @(negedge clk);
    proc_in_ready = 0;
  endtask

  task automatic ppush(input logic [7:0] d);
    proc_out_data = d; proc_out_valid = 1;
    @(negedge clk);
    proc_out_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", host_rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 in_valid", {7'b0, proc_in_valid}, 8'h00);
    hread(6'h04, 8'h00, "R1 flags");
    hread(6'h03, 8'h40, "R1 out status");
    hread(6'h16, 8'h00, "R2 not ready");
    proc_dl_ready = 1;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[7:0], i);
      case (v[31:30])
        2'd0: hwrite(v[29:24], v[23:16]);
        2'd1: hread(v[29:24], v[15:8], tag);
        2'd2: ppop(v[15:8], tag);
        default: ppush(v[23:16]);
      endcase
    end
    hwrite(6'h04, 8'h00);

    // R8 interrupt follows outbound occupancy
    chk("R8 idle", {7'b0, irq}, 8'h00);
    ppush(8'h3C);
    chk("R8 raised", {7'b0, irq}, 8'h01);
    hread(6'h01, 8'h3C, "R6 single");
    chk("R8 cleared", {7'b0, irq}, 8'h00);

    // R10 toggling swap discards a held byte
    hwrite(6'h04, 8'h04);
    hwrite(6'h00, 8'h77);
    hread(6'h02, 8'h40, "R9 held byte not counted");
    hwrite(6'h04, 8'h00);
    hwrite(6'h00, 8'h88);
    hread(6'h02, 8'h01, "R10 discard count");
    ppop(8'h88, "R10 discard data");

    // R11 inbound push and pop in the same cycle
    hwrite(6'h00, 8'h91);
    host_addr = 6'h00; host_wdata = 8'h92; host_wr = 1;
    chk("R11 in head", proc_in_data, 8'h91);
    proc_in_ready = 1;
    @(negedge clk);
    host_wr = 0; proc_in_ready = 0;
    hread(6'h02, 8'h01, "R11 in count");
    ppop(8'h92, "R11 in next");

    // R11 outbound push and host pop in the same cycle
    ppush(8'hD1);
    host_addr = 6'h01; host_rd = 1;
    proc_out_data = 8'hD2; proc_out_valid = 1;
    @(negedge clk);
    host_rd = 0; proc_out_valid = 0;
    chk("R11 out data", host_rdata, 8'hD1);
    hread(6'h03, 8'h01, "R11 out count");
    hread(6'h01, 8'hD2, "R11 out next");

    // R5 fill to capacity, then one more write
    for (int i = 0; i < 32; i++) hwrite(6'h00, 8'(i + 8'h40));
    hread(6'h02, 8'hA0, "R5 full status");
    chk("R5 full valid", {7'b0, proc_in_valid}, 8'h01);
    hwrite(6'h00, 8'hEE);
    hread(6'h04, 8'h01, "R5 overflow flag");
    for (int i = 0; i < 32; i++) ppop(8'(i + 8'h40), "R5 drain");
    chk("R5 drained", {7'b0, proc_in_valid}, 8'h00);
    hread(6'h04, 8'h01, "R5 flag sticky");
    hwrite(6'h04, 8'h01);
    hread(6'h04, 8'h00, "R10 overflow cleared");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule